// File: doc/BRIEF.md
# Color Palette Store with Indexed Access

This block keeps the color palettes for a tile-based display: 128 bytes, split into a background set of 64 bytes and an object set of 64 bytes. Each set is reached through its own pair of CPU ports. An index port selects a byte within the set. A data port reads or writes that byte.

If the auto-advance flag in an index port is set, each accepted data write steps the index to the next byte. Firmware can therefore stream a whole palette with a single index write.

Every two consecutive bytes form one 15-bit color. A combinational lookup port lets the pixel pipeline fetch any of the 64 colors as 24-bit RGB.

Data writes only take effect while the color-mode input is high. Index writes and all reads work in either mode.

The CPU port select `cpu_sel_i` uses these codes:

| Code | Port |
|---|---|
| 0 | background index |
| 1 | background data |
| 2 | object index |
| 3 | object data |

Internally, each write is decoded into one of four access kinds: ACC_NONE, ACC_IDX_WR, ACC_DAT_WR and ACC_DAT_BLOCKED. The last kind is a data write made while color mode is low. Each index register moves as follows:
- ACC_IDX_WR loads the register.
- ACC_DAT_WR advances it only when its flag is set.
- Every other kind holds it.

Top module: `cpal_top`

## Requirements
- R1: After reset, both index ports read 0x40. The store is cleared, so every lookup returns 0x000000.
- R2: A write to an index port stores bit 7 (auto-advance flag) and bits 5:0 (byte address). Bit 6 always reads back as 1, whatever value was written to it.
- R3: A data-port write with color mode high stores the byte at the set's current index. Background bytes occupy store offsets 0–63 and object bytes occupy 64–127. A later data-port read at that index returns the byte.
- R4: When the flag is set, an accepted data write advances bits 5:0 by one, and bit 7 stays set.
- R5: The advance wraps from address 63 to address 0 and leaves bit 7 unchanged.
- R6: When the flag is clear, a data write leaves the index unchanged.
- R7: Reading a data or index port never changes any index or any stored byte.
- R8: With color mode low, a data-port write changes neither the store nor the index.
- R9: Lookup of color c (0–31 background, 32–63 object) forms a 16-bit word. Its low byte is store byte 2c and its high byte is store byte 2c+1. Red is word[4:0], green is word[9:5] and blue is word[14:10]; word[15] is ignored. Each 5-bit component is shifted left by 3 with zeros below. The output is {red8, green8, blue8}, with red in bits 23:16.
- R10: Index and data accesses to one set leave the other set's index and bytes untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| color_mode_i | input | 1 | Enables data-port writes |
| cpu_sel_i | input | 2 | Port select: 0 bg index, 1 bg data, 2 obj index, 3 obj data |
| cpu_wr_i | input | 1 | Write strobe for the selected port |
| cpu_wdata_i | input | 8 | Write data |
| cpu_rdata_o | output | 8 | Read data of the selected port (combinational) |
| lut_color_i | input | 6 | Color number for RGB lookup |
| lut_rgb_o | output | 24 | Expanded RGB of the selected color |

## Verification
A corrupted index register is visible on the index port in the cycle after the faulty write. It is also visible indirectly, because the next data write lands on the wrong byte.

A byte written to the wrong place, or a write that should have been blocked, shows up combinationally on `lut_rgb_o` one clock after the write edge. The reference model compares both outputs on every cycle, so any divergence is reported in the cycle it first becomes visible.

// File: rtl/cpal_pkg.sv
package cpal_pkg;

    // Port codes carried on cpu_sel_i: bit 1 picks the set, bit 0 picks index or data.
    typedef enum logic [1:0] {
        PORT_BG_IDX  = 2'd0,
        PORT_BG_DAT  = 2'd1,
        PORT_OBJ_IDX = 2'd2,
        PORT_OBJ_DAT = 2'd3
    } port_e;

    // Decoded access seen by one palette set in one cycle.
    typedef enum logic [1:0] {
        ACC_NONE        = 2'd0,
        ACC_IDX_WR      = 2'd1,
        ACC_DAT_WR      = 2'd2,
        ACC_DAT_BLOCKED = 2'd3
    } acc_e;

    // Widen one color component to an output channel, padding with zeros below.
    function automatic logic [7:0] widen_comp(input logic [4:0] c);
        return {c, 3'b000};
    endfunction

endpackage

// File: rtl/cpal_index_reg.sv
module cpal_index_reg
    import cpal_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  acc_e          acc_i,
    input  logic [7:0]    wdata_i,
    output logic [AW-1:0] addr_o,
    output logic [7:0]    rb_o
);
    localparam logic [7:0] FIXED_ONE = 8'h40;

    logic          adv_q, adv_d;
    logic [AW-1:0] addr_q, addr_d;

    // Next-state logic.
    always_comb begin
        adv_d  = adv_q;
        addr_d = addr_q;
        unique case (acc_i)
            ACC_IDX_WR: begin
                adv_d  = wdata_i[7];
                addr_d = wdata_i[AW-1:0];
            end
            ACC_DAT_WR: begin
                if (adv_q) addr_d = addr_q + AW'(1);
            end
            ACC_NONE, ACC_DAT_BLOCKED: ;
            default: ;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            adv_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            adv_q  <= adv_d;
            addr_q <= addr_d;
        end
    end

    // Outputs.
    always_comb begin
        addr_o = addr_q;
        rb_o   = FIXED_ONE | {adv_q, 7'(addr_q)};
    end
endmodule

// File: rtl/cpal_store.sv
module cpal_store #(
    parameter int SETS = 2,
    parameter int AW   = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [LAW-1:0]   waddr_i,
    input  logic [7:0]       wdata_i,
    input  logic [LAW-1:0]   raddr_i,
    output logic [7:0]       rdata_o,
    input  logic [LAW-2:0]   cidx_i,
    output logic [15:0]      cword_o
);
    localparam int LAW   = AW + $clog2(SETS);
    localparam int DEPTH = 1 << LAW;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    always_comb begin
        rdata_o = mem_q[raddr_i];
        cword_o = {mem_q[{cidx_i, 1'b1}], mem_q[{cidx_i, 1'b0}]};
    end
endmodule

// File: rtl/cpal_expand.sv
module cpal_expand
    import cpal_pkg::*;
#(
    parameter int COMPS  = 3,
    parameter int COMP_W = 5
) (
    input  logic [15:0]        word_i,
    output logic [COMPS*8-1:0] rgb_o
);
    // Component k sits at word bits [k*COMP_W +: COMP_W]; red (k=0) goes to the top channel.
    for (genvar k = 0; k < COMPS; k++) begin : g_comp
        assign rgb_o[(COMPS-1-k)*8 +: 8] = widen_comp(word_i[k*COMP_W +: COMP_W]);
    end
endmodule

// File: rtl/cpal_top.sv
module cpal_top
    import cpal_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        color_mode_i,
    input  logic [1:0]  cpu_sel_i,
    input  logic        cpu_wr_i,
    input  logic [7:0]  cpu_wdata_i,
    output logic [7:0]  cpu_rdata_o,
    input  logic [5:0]  lut_color_i,
    output logic [23:0] lut_rgb_o
);
    localparam int SETS = 2;
    localparam int LAW  = AW + $clog2(SETS);

    acc_e          acc      [SETS];
    logic [AW-1:0] set_addr [SETS];
    logic [7:0]    set_rb   [SETS];
    logic [7:0]    bg_idx_rb, obj_idx_rb;
    logic          set_sel, is_data, store_we;
    logic [LAW-1:0] byte_addr;
    logic [7:0]    store_rd;
    logic [15:0]   cword;

    assign set_sel = cpu_sel_i[1];
    assign is_data = cpu_sel_i[0];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        always_comb begin
            if (!cpu_wr_i || (set_sel != 1'(s)))
                acc[s] = ACC_NONE;
            else if (!is_data)
                acc[s] = ACC_IDX_WR;
            else if (color_mode_i)
                acc[s] = ACC_DAT_WR;
            else
                acc[s] = ACC_DAT_BLOCKED;
        end

        cpal_index_reg #(.AW(AW)) u_idx (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .acc_i   (acc[s]),
            .wdata_i (cpu_wdata_i),
            .addr_o  (set_addr[s]),
            .rb_o    (set_rb[s])
        );
    end

    assign bg_idx_rb  = set_rb[0];
    assign obj_idx_rb = set_rb[1];
    assign byte_addr  = {set_sel, set_addr[set_sel]};
    assign store_we   = (acc[0] == ACC_DAT_WR) || (acc[1] == ACC_DAT_WR);

    cpal_store #(.SETS(SETS), .AW(AW)) u_store (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (store_we),
        .waddr_i (byte_addr),
        .wdata_i (cpu_wdata_i),
        .raddr_i (byte_addr),
        .rdata_o (store_rd),
        .cidx_i  (lut_color_i),
        .cword_o (cword)
    );

    cpal_expand u_exp (
        .word_i (cword),
        .rgb_o  (lut_rgb_o)
    );

    assign cpu_rdata_o = is_data ? store_rd : set_rb[set_sel];
endmodule

// File: rtl/cpal_checker.sv
module cpal_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       color_mode_i,
    input logic [1:0] cpu_sel_i,
    input logic       cpu_wr_i,
    input logic [7:0] bg_idx_rb,
    input logic [7:0] obj_idx_rb
);
    assert_reset_idx_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (bg_idx_rb == 8'h40 && obj_idx_rb == 8'h40));

    assert_advance_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cpu_wr_i && cpu_sel_i == 2'd1 && color_mode_i && bg_idx_rb[7]) |=>
        (bg_idx_rb[5:0] == 6'($past(bg_idx_rb[5:0]) + 6'd1) && bg_idx_rb[7]));

    assert_hold_noflag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cpu_wr_i && cpu_sel_i == 2'd3 && !obj_idx_rb[7]) |=> $stable(obj_idx_rb));

    assert_read_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cpu_wr_i |=> ($stable(bg_idx_rb) && $stable(obj_idx_rb)));

    assert_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cpu_wr_i && cpu_sel_i[0] && !color_mode_i) |=>
        ($stable(bg_idx_rb) && $stable(obj_idx_rb)));

    assert_isolation_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cpu_wr_i && !cpu_sel_i[1]) |=> $stable(obj_idx_rb));
endmodule

bind cpal_top cpal_checker chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .color_mode_i (color_mode_i),
    .cpu_sel_i    (cpu_sel_i),
    .cpu_wr_i     (cpu_wr_i),
    .bg_idx_rb    (bg_idx_rb),
    .obj_idx_rb   (obj_idx_rb)
);

// File: tb/cpal_top_tb_top.sv
`timescale 1ns/1ps
module cpal_top_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        color_mode_i = 1'b1;
    logic [1:0]  cpu_sel_i = 2'd0;
    logic        cpu_wr_i = 1'b0;
    logic [7:0]  cpu_wdata_i = 8'h00;
    logic [5:0]  lut_color_i = 6'd0;
    logic [7:0]  cpu_rdata_o;
    logic [23:0] lut_rgb_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Reference model state.
    int ref_mem [128];
    int ref_adv [2];
    int ref_addr[2];

    always #2.5 clk_i = ~clk_i;

    cpal_top dut_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .color_mode_i (color_mode_i),
        .cpu_sel_i    (cpu_sel_i),
        .cpu_wr_i     (cpu_wr_i),
        .cpu_wdata_i  (cpu_wdata_i),
        .cpu_rdata_o  (cpu_rdata_o),
        .lut_color_i  (lut_color_i),
        .lut_rgb_o    (lut_rgb_o)
    );

    function automatic int exp_read(input int sel);
        int s = sel / 2;
        if (sel % 2 == 0) return 'h40 | (ref_adv[s] << 7) | ref_addr[s];
        return ref_mem[s*64 + ref_addr[s]];
    endfunction

    function automatic int exp_rgb(input int c);
        int w = ref_mem[2*c] | (ref_mem[2*c+1] << 8);
        int r = w & 31;
        int g = (w >> 5) & 31;
        int b = (w >> 10) & 31;
        return (r << 19) | (g << 11) | (b << 3);
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // One clock: drive at the falling edge, compare, then advance the model past the next rising edge.
    task automatic cyc(input int sel, input bit wr, input int wd, input bit cm, input int lc,
                       input string tag);
        int s;
        @(negedge clk_i);
        cpu_sel_i    = 2'(sel);
        cpu_wr_i     = wr;
        cpu_wdata_i  = 8'(wd);
        color_mode_i = cm;
        lut_color_i  = 6'(lc);
        #1;
        n_checks++;
        if (int'(cpu_rdata_o) != exp_read(sel)) begin
            n_fail++;
            $display("FAIL %s rdata sel=%0d actual=%02h expected=%02h", tag, sel, cpu_rdata_o, exp_read(sel));
        end
        n_checks++;
        if (int'(lut_rgb_o) != exp_rgb(lc)) begin
            n_fail++;
            $display("FAIL %s rgb color=%0d actual=%06h expected=%06h", tag, lc, lut_rgb_o, exp_rgb(lc));
        end
        s = sel / 2;
        if (wr) begin
            if (sel % 2 == 0) begin
                ref_adv[s]  = (wd >> 7) & 1;
                ref_addr[s] = wd & 63;
            end else if (cm) begin
                ref_mem[s*64 + ref_addr[s]] = wd & 255;
                if (ref_adv[s] != 0) ref_addr[s] = (ref_addr[s] + 1) & 63;
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int i = 0; i < 128; i++) ref_mem[i] = 0;
        ref_adv  = '{0, 0};
        ref_addr = '{0, 0};
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;

        // R1: reset state
        cyc(0, 0, 0, 1, 0, "R1");
        cyc(2, 0, 0, 1, 63, "R1");
        cyc(1, 0, 0, 1, 31, "R1");

        // R2: index field storage, bit 6 forced
        cyc(0, 1, 'h05, 1, 0, "R2");
        cyc(0, 0, 0, 1, 0, "R2");
        cyc(0, 1, 'hBF, 1, 0, "R2");
        cyc(0, 0, 0, 1, 0, "R2");
        cyc(2, 1, 'h7A, 1, 0, "R2");
        cyc(2, 0, 0, 1, 0, "R2");

        // R3 and R6: no-advance data write, then readback
        cyc(0, 1, 'h10, 1, 0, "R3");
        cyc(1, 1, 'hA5, 1, 8, "R6");
        cyc(1, 0, 0, 1, 8, "R3");
        cyc(0, 0, 0, 1, 8, "R6");

        // R4: streamed writes with auto-advance
        cyc(0, 1, 'h82, 1, 1, "R4");
        for (int i = 0; i < 6; i++) cyc(1, 1, 'h31 + 17*i, 1, 1, "R4");
        cyc(0, 0, 0, 1, 2, "R4");

        // R5: wrap from 63 to 0 in the object set
        cyc(2, 1, 'hBE, 1, 63, "R5");
        cyc(3, 1, 'hFF, 1, 63, "R5");
        cyc(3, 1, 'h7C, 1, 63, "R5");
        cyc(2, 0, 0, 1, 63, "R5");
        cyc(3, 1, 'h5A, 1, 32, "R5");
        cyc(2, 0, 0, 1, 32, "R5");

        // R7: repeated reads leave everything unchanged
        for (int i = 0; i < 4; i++) cyc(i, 0, 0, 1, 32, "R7");
        cyc(1, 0, 0, 1, 0, "R7");
        cyc(3, 0, 0, 0, 32, "R7");

        // R8: data writes with color mode low are dropped
        cyc(1, 1, 'h99, 0, 3, "R8");
        cyc(3, 1, 'h66, 0, 32, "R8");
        cyc(0, 0, 0, 0, 3, "R8");
        cyc(2, 0, 0, 0, 32, "R8");
        cyc(1, 0, 0, 1, 3, "R8");

        // R10: object-set traffic leaves the background set alone
        cyc(0, 0, 0, 1, 1, "R10");
        cyc(2, 1, 'h82, 1, 1, "R10");
        cyc(3, 1, 'hEE, 1, 1, "R10");
        cyc(0, 0, 0, 1, 1, "R10");
        cyc(1, 0, 0, 1, 33, "R10");

        // R9: fill all 128 bytes through both sets, then look up every color
        cyc(0, 1, 'h80, 1, 0, "R9");
        for (int i = 0; i < 64; i++) cyc(1, 1, (i*37 + 11) & 255, 1, i/2, "R9");
        cyc(2, 1, 'h80, 1, 0, "R9");
        for (int i = 0; i < 64; i++) cyc(3, 1, (i*91 + 200) & 255, 1, 32 + i/2, "R9");
        for (int c = 0; c < 64; c++) cyc(c % 4, 0, 0, 1, c, "R9");

        // R9: high bit of the high byte is ignored
        cyc(0, 1, 'h8A, 1, 5, "R9");
        cyc(1, 1, 'hFF, 1, 5, "R9");
        cyc(1, 1, 'hFF, 1, 5, "R9");
        cyc(0, 1, 'h0B, 1, 5, "R9");
        cyc(1, 1, 'h7F, 1, 5, "R9");
        cyc(1, 0, 0, 1, 5, "R9");

        summary();
    end
endmodule